// File: doc/BRIEF.md
# Serial Byte Transmitter with Programmable Framing

This block turns a stream of bytes into an asynchronous serial line. Bytes enter through a valid/ready port and wait in a 32-entry queue. A shift engine takes them one at a time and sends each as a frame: a low start bit, then 5 to 8 data bits with the least significant first, then an optional parity bit, then one, one and a half or two high stop bits. Each bit lasts a whole number of clock cycles, set by a 16-bit divider. A break input holds the line low for as long as it is set.

The framing controls (word length, parity mode, stop-bit select and divider) are plain level inputs. The engine samples them when it takes a byte from the queue, so a change only affects the next character. Status outputs report the queue fill level, full and empty, and an all-idle indication. There is a one-cycle pulse when the queue runs dry and a sticky overflow flag for bytes that were offered while the queue was full.

Back-pressure rules: a byte is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low exactly when the queue is full. A byte offered while `in_ready` is low is dropped and sets the overflow flag. During a cycle with `fifo_flush` high, no byte is stored.

Top module: `serial_tx_engine`

## Requirements
- R1: One bit time is P = max(cfg_div, 11) + 2 clock cycles. When the engine is idle, a byte accepted on edge E is taken on edge E+1, and the start bit (line low) begins right after E+1 and lasts P cycles.
- R2: cfg_wlen selects the number of data bits as 5 + cfg_wlen (0 gives 5, 3 gives 8). Data bits go out least significant first, one bit time each. Byte bits above the word length are not sent.
- R3: With cfg_par_en = 1 a parity bit follows the data. If cfg_par_stick = 1 the parity bit is the constant 0 when cfg_par_even = 1 and the constant 1 when cfg_par_even = 0. Otherwise it makes the count of ones in data plus parity even (cfg_par_even = 1) or odd (cfg_par_even = 0). With cfg_par_en = 0 there is no parity bit.
- R4: The stop period is high. It lasts P cycles when cfg_two_stop = 0. With cfg_two_stop = 1 it lasts P + floor(P/2) cycles for 5-bit words and 2P cycles for the other word lengths.
- R5: While cfg_break is high, tx is low in that same cycle. The frame timing goes on underneath the break, and tx returns to the framed value once cfg_break falls.
- R6: tx_idle is high exactly when the queue is empty and the engine has finished the last stop cycle. It rises in the cycle right after the final stop cycle. When the engine is idle and no break is set, tx is high.
- R7: in_ready = !fifo_full. A byte offered while the queue is full is dropped and sets tx_ovf on the next edge. tx_ovf stays set until an edge with ovf_clear high. If a new overflow happens on the same edge as the clear, the set wins.
- R8: A pulse on fifo_flush empties the queue by the next edge and drops any byte offered in that same cycle. A character already being shifted out completes normally.
- R9: thre_irq is high for one cycle, right after the edge on which the engine takes the last queued byte while no new byte is accepted.
- R10: fifo_level (6 bits) counts the stored bytes from 0 to 32. fifo_full is high at 32 and fifo_empty is high at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 16 | Bit-time divider; values below 11 act as 11 |
| cfg_wlen | input | 2 | Word length code, 5 + code data bits |
| cfg_two_stop | input | 1 | Select the longer stop period |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_even | input | 1 | Even parity (1) or odd parity (0) |
| cfg_par_stick | input | 1 | Use a constant parity bit |
| cfg_break | input | 1 | Force the line low |
| fifo_flush | input | 1 | Empty the queue |
| ovf_clear | input | 1 | Clear the overflow flag |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_ready | output | 1 | Queue can accept a byte |
| tx | output | 1 | Serial line |
| fifo_level | output | 6 | Number of queued bytes |
| fifo_full | output | 1 | Queue holds 32 bytes |
| fifo_empty | output | 1 | Queue holds no byte |
| tx_idle | output | 1 | Queue empty and shifter finished |
| thre_irq | output | 1 | One-cycle pulse when the queue runs dry |
| tx_ovf | output | 1 | Sticky overflow flag |

## Verification
For a byte accepted on edge E into an idle engine, every result has a fixed due cycle. The line is still high at the first falling edge after E. The start bit and the thre_irq pulse appear at the next falling edge, which is cycle 0. Bit k of the frame then covers cycles k·P to k·P+P−1, and tx_idle must be low in the last stop cycle and high one cycle later. The bench samples tx at every falling edge of each frame against a segment index it computes from P and the configuration. Queue level, overflow and flush results are read on the first falling edge after the edge that causes them, and break is checked on the falling edge after it is raised, since it acts on tx in the same cycle.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } frame_cfg_t;

  // Parity over the active data bits; stick mode gives a constant.
  function automatic logic calc_parity(input logic [DATA_W-1:0] d,
                                       input logic [1:0] wlen,
                                       input logic even,
                                       input logic stick);
    logic [DATA_W-1:0] m;
    m = d & (8'hFF >> (2'd3 - wlen));
    if (stick) return ~even;
    return even ? (^m) : ~(^m);
  endfunction

endpackage

// File: rtl/serial_tx_fifo.sv
module serial_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              pop_data,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + LW'(1);
        2'b01:   count <= count - LW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

  assign pop_data = mem[rd_ptr];
  assign level    = count;
  assign full     = (count == LW'(DEPTH));
  assign empty    = (count == '0);

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0)); // R8
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R10
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> full); // R10

endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter
  import serial_tx_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int DIV_MIN = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  frame_cfg_t        cfg,
  input  logic              avail,
  input  logic [DATA_W-1:0] data,
  output logic              take,
  output logic              line,
  output logic              idle
);
  localparam int CNT_W = DIV_W + 3;

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q, period_q, stop_q;
  logic [DATA_W-1:0] sreg_q;
  logic [2:0]        bidx_q;
  logic [1:0]        wlen_q;
  logic              par_en_q, par_q, line_q;

  logic [CNT_W-1:0] p_new, stop_new, limit;
  logic             at_end;

  always_comb begin
    p_new = ((div < DIV_W'(DIV_MIN)) ? CNT_W'(DIV_MIN) : CNT_W'(div)) + CNT_W'(2);
    if (!cfg.two_stop)          stop_new = p_new;
    else if (cfg.wlen == 2'd0)  stop_new = p_new + (p_new >> 1);
    else                        stop_new = p_new << 1;
    limit  = (state_q == ST_STOP) ? stop_q : period_q;
    at_end = (cnt_q == limit - CNT_W'(1));
    take   = avail && ((state_q == ST_IDLE) || (state_q == ST_STOP && at_end));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      period_q <= CNT_W'(DIV_MIN + 2);
      stop_q   <= CNT_W'(DIV_MIN + 2);
      sreg_q   <= '0;
      bidx_q   <= '0;
      wlen_q   <= '0;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
      line_q   <= 1'b1;
    end else if (take) begin
      state_q  <= ST_START;
      cnt_q    <= '0;
      period_q <= p_new;
      stop_q   <= stop_new;
      sreg_q   <= data;
      bidx_q   <= '0;
      wlen_q   <= cfg.wlen;
      par_en_q <= cfg.par_en;
      par_q    <= calc_parity(data, cfg.wlen, cfg.par_even, cfg.par_stick);
      line_q   <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (at_end) begin
        cnt_q <= '0;
        case (state_q)
          ST_START: begin
            line_q  <= sreg_q[0];
            sreg_q  <= sreg_q >> 1;
            state_q <= ST_DATA;
          end
          ST_DATA: begin
            if (bidx_q == {1'b1, wlen_q}) begin
              line_q  <= par_en_q ? par_q : 1'b1;
              state_q <= par_en_q ? ST_PAR : ST_STOP;
            end else begin
              line_q <= sreg_q[0];
              sreg_q <= sreg_q >> 1;
              bidx_q <= bidx_q + 3'd1;
            end
          end
          ST_PAR: begin
            line_q  <= 1'b1;
            state_q <= ST_STOP;
          end
          default: begin
            line_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        endcase
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign line = line_q;
  assign idle = (state_q == ST_IDLE);

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!line && state_q == ST_START)); // R1
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> line); // R6
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> line); // R4

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import serial_tx_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int DIV_W   = 16,
  parameter int DIV_MIN = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DIV_W-1:0]       cfg_div,
  input  logic [1:0]             cfg_wlen,
  input  logic                   cfg_two_stop,
  input  logic                   cfg_par_en,
  input  logic                   cfg_par_even,
  input  logic                   cfg_par_stick,
  input  logic                   cfg_break,
  input  logic                   fifo_flush,
  input  logic                   ovf_clear,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_data,
  output logic                   in_ready,
  output logic                   tx,
  output logic [$clog2(DEPTH):0] fifo_level,
  output logic                   fifo_full,
  output logic                   fifo_empty,
  output logic                   tx_idle,
  output logic                   thre_irq,
  output logic                   tx_ovf
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic              push, take, line, sh_idle;
  logic [DATA_W-1:0] head;
  logic              ovf_q, thre_q;
  frame_cfg_t        fcfg;

  assign fcfg = '{wlen: cfg_wlen, two_stop: cfg_two_stop, par_en: cfg_par_en,
                  par_even: cfg_par_even, par_stick: cfg_par_stick};

  assign in_ready = !fifo_full;
  assign push     = in_valid && in_ready && !fifo_flush;

  serial_tx_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(fifo_flush),
    .push(push), .push_data(in_data),
    .pop(take), .pop_data(head),
    .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
  );

  serial_tx_shifter #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) shifter_i (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .cfg(fcfg),
    .avail(!fifo_empty), .data(head),
    .take(take), .line(line), .idle(sh_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      thre_q <= 1'b0;
    end else begin
      if (in_valid && fifo_full) ovf_q <= 1'b1;
      else if (ovf_clear)        ovf_q <= 1'b0;
      thre_q <= take && (fifo_level == LW'(1)) && !push;
    end
  end

  assign tx       = line && !cfg_break;
  assign tx_idle  = sh_idle && fifo_empty;
  assign thre_irq = thre_q;
  assign tx_ovf   = ovf_q;

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> tx_ovf); // R7
  AST_THRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> fifo_empty); // R9
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && !cfg_break) |-> tx); // R6

endmodule

// File: tb/serial_tx_engine_tb.sv
`timescale 1ns/1ps
module serial_tx_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd11;
  logic [1:0]  cfg_wlen = 2'd3;
  logic        cfg_two_stop = 0, cfg_par_en = 0, cfg_par_even = 0, cfg_par_stick = 0;
  logic        cfg_break = 0, fifo_flush = 0, ovf_clear = 0, in_valid = 0;
  logic [7:0]  in_data = '0;
  logic        in_ready, tx, fifo_full, fifo_empty, tx_idle, thre_irq, tx_ovf;
  logic [5:0]  fifo_level;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  serial_tx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_wlen(cfg_wlen),
    .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick),
    .cfg_break(cfg_break), .fifo_flush(fifo_flush), .ovf_clear(ovf_clear),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .tx(tx),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .tx_idle(tx_idle), .thre_irq(thre_irq), .tx_ovf(tx_ovf)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // pm: 0 none, 1 odd, 2 even, 3 stick with odd select, 4 stick with even select
  task automatic run_frame(input logic [7:0] d, input int wl, input int pm,
                           input bit two, input int div, input int brk_k);
    int p, n, pe, stop, total, par, seg, expv;
    logic [7:0] m;
    string tag;
    cfg_div = 16'(div); cfg_wlen = 2'(wl); cfg_two_stop = two;
    cfg_par_en = (pm != 0); cfg_par_even = (pm == 2 || pm == 4);
    cfg_par_stick = (pm >= 3);
    p = ((div < 11) ? 11 : div) + 2;
    n = 5 + wl;
    pe = (pm != 0) ? 1 : 0;
    m = d & 8'((1 << n) - 1);
    case (pm)
      1: par = (^m) ? 0 : 1;
      2: par = (^m) ? 1 : 0;
      3: par = 1;
      default: par = 0;
    endcase
    stop = two ? ((wl == 0) ? p + p / 2 : 2 * p) : p;
    total = p * (1 + n + pe) + stop;
    @(negedge clk); in_valid = 1'b1; in_data = d;
    @(negedge clk); in_valid = 1'b0;
    chk(int'(tx), 1, "R1 line high before take");
    chk(int'(fifo_empty), 0, "R10 byte queued");
    for (int k = 0; k <= total; k++) begin
      @(negedge clk);
      seg = k / p;
      if (k >= total)              begin expv = 1; tag = "R6 idle line"; end
      else if (seg == 0)           begin expv = 0; tag = "R1 start bit"; end
      else if (seg <= n)           begin expv = int'(m[seg-1]); tag = "R2 data bit"; end
      else if (pe == 1 && seg == n + 1) begin expv = par; tag = "R3 parity bit"; end
      else                         begin expv = 1; tag = "R4 stop period"; end
      if (k == brk_k + 1) begin expv = 0; tag = "R5 break low"; end
      chk(int'(tx), expv, tag);
      if (k == 0) chk(int'(thre_irq), 1, "R9 pulse on last take");
      if (k == 1) chk(int'(thre_irq), 0, "R9 pulse one cycle");
      if (k == total - 1) chk(int'(tx_idle), 0, "R4 R6 busy in last stop cycle");
      if (k == total) chk(int'(tx_idle), 1, "R6 idle after stop");
      if (k == brk_k) cfg_break = 1'b1;
      if (k == brk_k + 1) cfg_break = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(tx), 1, "R6 reset line high");
    chk(int'(tx_idle), 1, "R6 reset idle");
    chk(int'(fifo_level), 0, "R10 reset level");
    chk(int'(fifo_empty), 1, "R10 reset empty");
    chk(int'(in_ready), 1, "R7 reset ready");
    chk(int'(tx_ovf), 0, "R7 reset ovf");
    chk(int'(thre_irq), 0, "R9 reset pulse");

    // Sweep of word length, parity mode and stop select
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 5; pm++)
        for (int two = 0; two < 2; two++)
          run_frame(8'hA5 ^ 8'(wl * 37 + pm * 11 + two * 3), wl, pm, bit'(two),
                    (pm == 1) ? 3 : (two == 1 ? 12 : 11), -10);
    run_frame(8'h3C, 3, 2, 1'b0, 20, -10);
    // Break during data bits
    run_frame(8'hFF, 3, 0, 1'b0, 11, 20);

    // Break while idle
    @(negedge clk); cfg_break = 1'b1;
    #1 chk(int'(tx), 0, "R5 break at idle");
    @(negedge clk); cfg_break = 1'b0;
    #1 chk(int'(tx), 1, "R5 break released");

    // Fill, overflow, clear, flush
    cfg_div = 16'd11; cfg_wlen = 2'd3; cfg_par_en = 0; cfg_two_stop = 0;
    @(negedge clk); in_valid = 1'b1;
    for (int i = 0; i < 33; i++) begin
      in_data = 8'(i);
      @(negedge clk);
      if (i == 16) chk(int'(fifo_level), 16, "R10 level while filling");
    end
    chk(int'(fifo_level), 32, "R10 level full");
    chk(int'(fifo_full), 1, "R10 full flag");
    chk(int'(in_ready), 0, "R7 ready low when full");
    chk(int'(tx_ovf), 0, "R7 no overflow yet");
    chk(int'(thre_irq), 0, "R9 no pulse while queued");
    @(negedge clk); in_valid = 1'b0;
    chk(int'(tx_ovf), 1, "R7 overflow set");
    chk(int'(fifo_level), 32, "R7 rejected byte dropped");
    ovf_clear = 1'b1;
    @(negedge clk); ovf_clear = 1'b0;
    chk(int'(tx_ovf), 0, "R7 overflow cleared");
    fifo_flush = 1'b1;
    @(negedge clk); fifo_flush = 1'b0;
    chk(int'(fifo_level), 0, "R8 flush empties");
    chk(int'(fifo_empty), 1, "R8 empty after flush");
    chk(int'(tx_idle), 0, "R8 character in flight");
    in_valid = 1'b1; fifo_flush = 1'b1; in_data = 8'h55;
    @(negedge clk); in_valid = 1'b0; fifo_flush = 1'b0;
    chk(int'(fifo_level), 0, "R8 write during flush dropped");
    for (int i = 0; i < 500 && !tx_idle; i++) @(negedge clk);
    chk(int'(tx_idle), 1, "R8 in-flight character completes");
    chk(int'(tx), 1, "R6 line high after completion");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule